// File: doc/BRIEF.md
# Synthesizer Serial Control Port

This block is the programming front end of a frequency-synthesizer control section. A host drives a slow serial clock and a data pin and moves one bit in on each rising serial-clock edge. Two strobe lines decide where the shifted bits go. The counter strobe commits a 21-bit word. The last bit of that word is a routing bit: 0 sends the word to the main divider register and 1 sends it to the fractional register. The enhancement strobe frames an 8-bit option word, and that word is committed when the strobe falls. All targets are holding registers, so a partly shifted word never reaches the decoded outputs.

A direct mode bypasses the serial path. While the direct pin is high, the main-divider and fractional fields come straight from parallel pins, and counter-strobe captures are dropped. The option bits reach their outputs only while the active-low option enable pin is low.

All control inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and edges are detected on the synchronized copies. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure: the serial host sets the pace and every pin is plain control.

Top module: `synth_ctrl_port`

## Requirements
- R1: On each synchronized rising edge of `ser_clk`, `ser_data` enters bit 0 of a 21-bit shift register and earlier bits move up one place. The first bit sent (B0) ends in bit 20 and the routing bit (B20) ends in bit 0. This happens while `enh_strobe` is low, and also while `enh_strobe` is high and `cnt_strobe` is low.
- R2: On a rising edge of `cnt_strobe` with routing bit 0 and direct mode off, shift bits 20..1 (B0..B19) load the main register. The decode is: `r_div` = {B0,B1,B12..B15}, `m_div` = {B2,B3,B5..B11}, `pre_en` = B4, `a_cnt` = B16..B19, each listed MSB first.
- R3: On a rising edge of `cnt_strobe` with routing bit 1 and direct mode off, B0..B17 load `k_frac` (B0 is the MSB) and B18, B19 are discarded. The main register is left unchanged.
- R4: On a falling edge of `enh_strobe`, the last 8 bits shifted (B0 first) load the option register. B0 and B1 are reserved. The outputs map as: B2 to `fp_sel`, B3 to `pwr_down`, B4 to `cnt_load`, B5 to `msel_sel`, B6 to `fc_sel`, B7 to `ld_off`.
- R5: The holding registers change only on their own strobe edge. Serial clocks between strobes leave every output unchanged.
- R6: The six option outputs equal their stored bits while `enh_n` is low and are all 0 while `enh_n` is high. The stored bits are kept while `enh_n` is high.
- R7: While `direct_sel` is high, the main fields decode `par_main` in the R2 layout (`par_main[19]` = B0) and `k_frac` equals `par_aux`. Counter strobes do not update the holding registers, so the stored values reappear when direct mode ends.
- R8: Reset clears the shift register and every holding register, so all outputs read 0.
- R9: If `cnt_strobe` rises after some number of serial clocks other than 21, the capture still uses the current shift-register contents, with the routing bit taken from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, sampled on rising `ser_clk` |
| cnt_strobe | input | 1 | Counter-word commit strobe, rising edge |
| enh_strobe | input | 1 | Option-word frame strobe, commit on falling edge |
| enh_n | input | 1 | Option enable, active low |
| direct_sel | input | 1 | High selects parallel pins for counter fields |
| par_main | input | 20 | Parallel main-divider word, R2 layout |
| par_aux | input | 18 | Parallel fractional word |
| r_div | output | 6 | Reference divider field |
| m_div | output | 9 | Main divider field |
| pre_en | output | 1 | Prescaler enable bit |
| a_cnt | output | 4 | Swallow counter field |
| k_frac | output | 18 | Fractional word |
| fp_sel | output | 1 | Option: fp output select |
| pwr_down | output | 1 | Option: power down |
| cnt_load | output | 1 | Option: counter load |
| msel_sel | output | 1 | Option: MSEL output select |
| fc_sel | output | 1 | Option: fc output select |
| ld_off | output | 1 | Option: lock-detect disable |

## Verification
A single wrong bit in the shift register stays invisible until the next strobe. It then shows up as one misplaced field bit, or as a word routed to the wrong target, about four system clocks after the strobe edge. A wrong holding register can be seen on its outputs continuously, so the bench samples the outputs in the middle of a shift as well as after each strobe. Wrong option gating shows within three clocks of an `enh_n` change.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int MAIN_W  = 20;
  localparam int AUX_W   = 18;
  localparam int OPT_W   = 6;
  localparam int SHIFT_W = MAIN_W + 1;

  typedef struct packed {
    logic [5:0] r_div;
    logic [8:0] m_div;
    logic       pre_en;
    logic [3:0] a_cnt;
  } main_fields_t;

  typedef struct packed {
    logic fp_sel;
    logic pwr_down;
    logic cnt_load;
    logic msel_sel;
    logic fc_sel;
    logic ld_off;
  } opt_fields_t;

  // Word bit 19 holds B0; word bit 0 holds B19.
  function automatic main_fields_t decode_main(input logic [MAIN_W-1:0] w);
    main_fields_t f;
    f.r_div  = {w[19:18], w[7:4]};
    f.m_div  = {w[17:16], w[14:8]};
    f.pre_en = w[15];
    f.a_cnt  = w[3:0];
    return f;
  endfunction
endpackage

// File: rtl/sc_sync.sv
module sc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sc_shifter.sv
module sc_shifter #(
  parameter int SH_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [SH_W-1:0] sh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh <= '0;
    else if (shift_en) sh <= {sh[SH_W-2:0], din};
  end
endmodule

// File: rtl/sc_hold.sv
module sc_hold
  import sc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] sh,
  input  logic               cap_cnt,
  input  logic               cap_opt,
  input  logic               direct,
  output logic [MAIN_W-1:0]  main_q,
  output logic [AUX_W-1:0]   aux_q,
  output logic [OPT_W-1:0]   opt_q
);
  // Shift bit 0 is the routing bit (last in).
  logic route_aux;
  assign route_aux = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      aux_q  <= '0;
    end else if (cap_cnt && !direct) begin
      if (route_aux) aux_q  <= sh[SHIFT_W-1 -: AUX_W];
      else           main_q <= sh[SHIFT_W-1:1];
    end
  end

  // Option word occupies the last 8 bits shifted; the 2 reserved bits are not stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       opt_q <= '0;
    else if (cap_opt) opt_q <= sh[OPT_W-1:0];
  end
endmodule

// File: rtl/synth_ctrl_port.sv
module synth_ctrl_port
  import sc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              cnt_strobe,
  input  logic              enh_strobe,
  input  logic              enh_n,
  input  logic              direct_sel,
  input  logic [MAIN_W-1:0] par_main,
  input  logic [AUX_W-1:0]  par_aux,
  output logic [5:0]        r_div,
  output logic [8:0]        m_div,
  output logic              pre_en,
  output logic [3:0]        a_cnt,
  output logic [AUX_W-1:0]  k_frac,
  output logic              fp_sel,
  output logic              pwr_down,
  output logic              cnt_load,
  output logic              msel_sel,
  output logic              fc_sel,
  output logic              ld_off
);
  localparam int N_IN = 6;

  logic [N_IN-1:0] raw_in, syn_in;
  logic sclk_s, sdat_s, cstb_s, estb_s, enh_n_s, direct_s;

  assign raw_in = {ser_clk, ser_data, cnt_strobe, enh_strobe, enh_n, direct_sel};

  sc_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign {sclk_s, sdat_s, cstb_s, estb_s, enh_n_s, direct_s} = syn_in;

  // Edge detection on synchronized copies
  logic sclk_d, cstb_d, estb_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cstb_d <= 1'b0;
      estb_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cstb_d <= cstb_s;
      estb_d <= estb_s;
    end
  end

  logic sclk_rise, s_rise, e_fall, shift_en;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign s_rise    = cstb_s & ~cstb_d;
  assign e_fall    = ~estb_s & estb_d;
  // Counter framing: enh strobe low. Option framing: enh strobe high, cnt strobe low.
  assign shift_en  = sclk_rise & ~(estb_s & cstb_s);

  logic [SHIFT_W-1:0] sh;
  sc_shifter #(.SH_W(SHIFT_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sdat_s), .sh(sh)
  );

  logic [MAIN_W-1:0] main_q;
  logic [AUX_W-1:0]  aux_q;
  logic [OPT_W-1:0]  opt_q;

  sc_hold hold_i (
    .clk(clk), .rst_n(rst_n), .sh(sh),
    .cap_cnt(s_rise), .cap_opt(e_fall), .direct(direct_s),
    .main_q(main_q), .aux_q(aux_q), .opt_q(opt_q)
  );

  // Output selection
  main_fields_t mf;
  opt_fields_t  of;

  always_comb begin
    mf = decode_main(direct_s ? par_main : main_q);
    of = enh_n_s ? '0 : opt_fields_t'(opt_q);
  end

  assign r_div    = mf.r_div;
  assign m_div    = mf.m_div;
  assign pre_en   = mf.pre_en;
  assign a_cnt    = mf.a_cnt;
  assign k_frac   = direct_s ? par_aux : aux_q;
  assign fp_sel   = of.fp_sel;
  assign pwr_down = of.pwr_down;
  assign cnt_load = of.cnt_load;
  assign msel_sel = of.msel_sel;
  assign fc_sel   = of.fc_sel;
  assign ld_off   = of.ld_off;
endmodule

// File: rtl/sc_port_chk.sv
module sc_port_chk
  import sc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              s_rise,
  input logic              e_fall,
  input logic              direct_s,
  input logic [MAIN_W-1:0] main_q,
  input logic [AUX_W-1:0]  aux_q,
  input logic [OPT_W-1:0]  opt_q,
  input logic [5:0]        opt_out
);
  // R5: main register moves only on a counter strobe edge
  p_main_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !s_rise |=> $stable(main_q));

  // R5: fractional register moves only on a counter strobe edge
  p_aux_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !s_rise |=> $stable(aux_q));

  // R4: option register moves only on the enh strobe falling edge
  p_opt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !e_fall |=> $stable(opt_q));

  // R3: a capture updates at most one target
  p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_rise |=> ($stable(main_q) || $stable(aux_q)));

  // R7: direct mode freezes the counter holding registers
  p_direct_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    direct_s |=> ($stable(main_q) && $stable(aux_q)));

  // R6: an option output is only ever driven from a stored 1
  p_opt_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opt_out != '0) |-> ((opt_out & ~opt_q) == '0));
endmodule

bind synth_ctrl_port sc_port_chk chk_i (
  .clk(clk), .rst_n(rst_n), .s_rise(s_rise), .e_fall(e_fall),
  .direct_s(direct_s), .main_q(main_q), .aux_q(aux_q), .opt_q(opt_q),
  .opt_out({fp_sel, pwr_down, cnt_load, msel_sel, fc_sel, ld_off})
);

// File: tb/synth_ctrl_port_tb_top.sv
module synth_ctrl_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, cnt_strobe = 1'b0, enh_strobe = 1'b0;
  logic enh_n = 1'b0, direct_sel = 1'b0;
  logic [19:0] par_main = '0;
  logic [17:0] par_aux = '0;
  logic [5:0]  r_div;
  logic [8:0]  m_div;
  logic        pre_en;
  logic [3:0]  a_cnt;
  logic [17:0] k_frac;
  logic fp_sel, pwr_down, cnt_load, msel_sel, fc_sel, ld_off;

  always #10 clk = ~clk;

  synth_ctrl_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .cnt_strobe(cnt_strobe), .enh_strobe(enh_strobe), .enh_n(enh_n),
    .direct_sel(direct_sel), .par_main(par_main), .par_aux(par_aux),
    .r_div(r_div), .m_div(m_div), .pre_en(pre_en), .a_cnt(a_cnt),
    .k_frac(k_frac), .fp_sel(fp_sel), .pwr_down(pwr_down),
    .cnt_load(cnt_load), .msel_sel(msel_sel), .fc_sel(fc_sel), .ld_off(ld_off)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model built from the requirements
  logic [20:0] m_sh   = '0;
  logic [19:0] e_main = '0;
  logic [17:0] e_aux  = '0;
  logic [7:0]  e_opt  = '0;

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [19:0] w;
    logic [17:0] k;
    w = direct_sel ? par_main : e_main;
    k = direct_sel ? par_aux : e_aux;
    chk(req, {26'd0, r_div}, {26'd0, w[19:18], w[7:4]});
    chk(req, {23'd0, m_div}, {23'd0, w[17:16], w[14:8]});
    chk(req, {31'd0, pre_en}, {31'd0, w[15]});
    chk(req, {28'd0, a_cnt}, {28'd0, w[3:0]});
    chk(req, {14'd0, k_frac}, {14'd0, k});
    chk(req, {26'd0, fp_sel, pwr_down, cnt_load, msel_sel, fc_sel, ld_off},
        enh_n ? 32'd0 : {26'd0, e_opt[5:0]});
  endtask

  task automatic ser_bit(input logic b);
    ser_data = b;
    wait_cyc(3);
    ser_clk = 1'b1;
    if (!(enh_strobe && cnt_strobe)) m_sh = {m_sh[19:0], b};
    wait_cyc(4);
    ser_clk = 1'b0;
    wait_cyc(3);
  endtask

  // Send the top n bits of w, starting at bit 20 (B0)
  task automatic send_bits(input logic [20:0] w, input int n);
    for (int i = 0; i < n; i++) ser_bit(w[20-i]);
  endtask

  task automatic cnt_commit();
    cnt_strobe = 1'b1;
    if (!direct_sel) begin
      if (m_sh[0]) e_aux = m_sh[20:3];
      else         e_main = m_sh[20:1];
    end
    wait_cyc(6);
    cnt_strobe = 1'b0;
    wait_cyc(6);
  endtask

  task automatic opt_load(input logic [7:0] v);
    enh_strobe = 1'b1;
    wait_cyc(6);
    for (int i = 7; i >= 0; i--) ser_bit(v[i]);
    enh_strobe = 1'b0;
    e_opt = m_sh[7:0];
    wait_cyc(6);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    // R8: reset state
    check_all("R8");

    // R1 R2: walking ones and patterns into the main register
    for (int b = 0; b < 20; b++) begin
      send_bits({20'(1) << b, 1'b0}, 21);
      cnt_commit();
      check_all("R2");
    end
    send_bits({20'hA5C3E, 1'b0}, 21);
    cnt_commit();
    check_all("R1");

    // R3: walking ones into the fractional register, main untouched
    for (int b = 0; b < 20; b++) begin
      send_bits({20'(1) << b, 1'b1}, 21);
      cnt_commit();
      check_all("R3");
    end

    // R5: mid-shift outputs do not move
    send_bits({20'h5A5A5, 1'b0}, 10);
    check_all("R5");
    send_bits({20'h0F0F0, 1'b1}, 7);
    check_all("R5");

    // R9: short word commits current shift contents
    send_bits({20'h3C3C3, 1'b0}, 5);
    cnt_commit();
    check_all("R9");
    send_bits({20'h12345, 1'b1}, 21);
    send_bits(21'h1FFFFF, 3);
    cnt_commit();
    check_all("R9");

    // R4 R6: sweep all option words, with enable toggles
    for (int v = 0; v < 256; v++) begin
      opt_load(8'(v));
      check_all("R4");
      if ((v % 32) == 5) begin
        enh_n = 1'b1;
        wait_cyc(5);
        check_all("R6");
        enh_n = 1'b0;
        wait_cyc(5);
        check_all("R6");
      end
    end

    // R7: direct mode follows pins and ignores counter strobes
    direct_sel = 1'b1;
    for (int p = 0; p < 6; p++) begin
      par_main = 20'hFFFFF ^ (20'h1111 << p);
      par_aux  = 18'h2AAAA >> p;
      wait_cyc(5);
      check_all("R7");
    end
    send_bits({20'hDEAD5, 1'b0}, 21);
    cnt_commit();
    send_bits({20'hBEEF3, 1'b1}, 21);
    cnt_commit();
    check_all("R7");
    direct_sel = 1'b0;
    wait_cyc(5);
    check_all("R7");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule